// File: doc/BRIEF.md
# Polarity-Aware GPIO Bank with Edge and Level Interrupts

This block is a bank of general-purpose pins behind a small register interface. Software sets the value driven on each pin, chooses per pin whether the driver is on, and can make any output toggle on its own. The driver enable is active low: a set bit leaves the pin as an input. Each pin also has a polarity bit. The polarity bit inverts the sampled pin level once, and the data-in register and both interrupt paths all see the inverted value.

A rising edge of the polarity-adjusted input latches a cause bit. Software clears cause bits by writing zeros to them. Two mask registers select the interrupt sources. The edge mask gates the latched causes, and the level mask gates the live adjusted input. A single interrupt output is the OR of every enabled source. Inputs are sampled once per clock. Reads return data combinationally, and writes take effect at the next rising clock edge. Reset is synchronous and active high.

Top module: `gpio_bank`

## Requirements
- R1: `pin_oe_n` equals the driver-enable register: a 0 bit drives the pin, a 1 bit makes it an input. The register resets to all ones.
- R2: For a pin whose blink bit is 0, `pin_out` equals that pin's data-out bit.
- R3: For a pin whose blink bit is 1, `pin_out` equals a shared blink phase. The phase is bit BLINK_EXP of a counter of clocks since reset. It starts low and toggles every 2^BLINK_EXP clocks.
- R4: Reading the data-in address returns the pin levels sampled at the previous clock edge, each XORed with its polarity bit.
- R5: A cause bit becomes set one clock after the matching data-in bit goes from 0 to 1. A polarity change that flips a bit from 0 to 1 also counts. A 1-to-0 change never sets a cause bit.
- R6: A write to the cause address clears every bit written as 0 and leaves every bit written as 1 unchanged. If a rising edge arrives in the same cycle as a clearing write, the cause bit is set.
- R7: `irq` is high exactly when some bit is set both in cause and in the edge mask, or both in data-in and in the level mask.
- R8: Reset clears data-out, blink, polarity, cause and both masks, sets the driver-enable register to all ones, and holds `irq` low.
- R9: The register addresses are 0 data-out, 1 driver-enable, 2 blink, 3 polarity, 4 data-in (read only, writes ignored), 5 cause, 6 edge mask and 7 level mask. Each writable register reads back the value last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | PIN_COUNT | Write data |
| reg_rdata | output | PIN_COUNT | Read data for the addressed register (combinational) |
| pin_in | input | PIN_COUNT | Pin levels from the pads |
| pin_out | output | PIN_COUNT | Values to drive on the pins |
| pin_oe_n | output | PIN_COUNT | Active-low driver enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench keeps the full 32-pin width, so every bit position of every register and of the cause clearing is exercised. It builds the block with BLINK_EXP set to 3. The blink phase then toggles every 8 clocks, and several full blink periods fit into a short run, which lets the bench compare the blink outputs against its reference model on every clock. Blinking pins and static pins are mixed in the same word, so the per-pin selection between blink and static output is checked directly.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_DOUT  = 3'd0,
        RA_OEN   = 3'd1,
        RA_BLINK = 3'd2,
        RA_POL   = 3'd3,
        RA_DIN   = 3'd4,
        RA_CAUSE = 3'd5,
        RA_EMASK = 3'd6,
        RA_LMASK = 3'd7
    } reg_addr_e;

    // One cause bit: a written 0 clears, a written 1 keeps, and a rise sets.
    function automatic logic cause_bit_next(input logic old_v, input logic wr_hit,
                                            input logic wr_v, input logic rise_v);
        return ((wr_hit ? (old_v & wr_v) : old_v) | rise_v);
    endfunction

endpackage

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      rise,
    output logic [W-1:0]      dout,
    output logic [W-1:0]      oen,
    output logic [W-1:0]      blink,
    output logic [W-1:0]      pol,
    output logic [W-1:0]      cause,
    output logic [W-1:0]      emask,
    output logic [W-1:0]      lmask
);

    typedef struct packed {
        logic [W-1:0] dout;
        logic [W-1:0] oen;
        logic [W-1:0] blink;
        logic [W-1:0] pol;
        logic [W-1:0] emask;
        logic [W-1:0] lmask;
    } ctrl_t;

    ctrl_t ctrl_q;
    logic  cause_hit;

    assign cause_hit = we && (reg_addr_e'(addr) == RA_CAUSE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.dout  <= '0;
            ctrl_q.oen   <= '1;
            ctrl_q.blink <= '0;
            ctrl_q.pol   <= '0;
            ctrl_q.emask <= '0;
            ctrl_q.lmask <= '0;
        end else if (we) begin
            case (reg_addr_e'(addr))
                RA_DOUT:  ctrl_q.dout  <= wdata;
                RA_OEN:   ctrl_q.oen   <= wdata;
                RA_BLINK: ctrl_q.blink <= wdata;
                RA_POL:   ctrl_q.pol   <= wdata;
                RA_EMASK: ctrl_q.emask <= wdata;
                RA_LMASK: ctrl_q.lmask <= wdata;
                default:  ;
            endcase
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_cause
        always_ff @(posedge clk) begin
            if (rst) cause[i] <= 1'b0;
            else     cause[i] <= cause_bit_next(cause[i], cause_hit, wdata[i], rise[i]);
        end
    end

    assign dout  = ctrl_q.dout;
    assign oen   = ctrl_q.oen;
    assign blink = ctrl_q.blink;
    assign pol   = ctrl_q.pol;
    assign emask = ctrl_q.emask;
    assign lmask = ctrl_q.lmask;

endmodule

// File: rtl/gpio_bank_inpath.sv
module gpio_bank_inpath #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] pol,
    output logic [W-1:0] din_adj,
    output logic [W-1:0] din_prev,
    output logic [W-1:0] rise
);

    logic [W-1:0] samp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q   <= '0;
            din_prev <= '0;
        end else begin
            samp_q   <= pin_in;
            din_prev <= din_adj;
        end
    end

    assign din_adj = samp_q ^ pol;
    assign rise    = din_adj & ~din_prev;

endmodule

// File: rtl/gpio_bank_blink.sv
module gpio_bank_blink #(
    parameter int EXP = 20
) (
    input  logic clk,
    input  logic rst,
    output logic phase
);

    localparam int CW = EXP + 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign phase = cnt_q[CW-1];

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int PIN_COUNT = 32,
    parameter int BLINK_EXP = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [2:0]           reg_addr,
    input  logic [PIN_COUNT-1:0] reg_wdata,
    output logic [PIN_COUNT-1:0] reg_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe_n,
    output logic                 irq
);

    logic [PIN_COUNT-1:0] dout, oen, blink, pol, cause, emask, lmask;
    logic [PIN_COUNT-1:0] din_adj, din_prev, rise;
    logic                 phase;
    logic [PIN_COUNT-1:0] pend;

    gpio_bank_regs #(.W(PIN_COUNT)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rise(rise), .dout(dout), .oen(oen), .blink(blink), .pol(pol),
        .cause(cause), .emask(emask), .lmask(lmask)
    );

    gpio_bank_inpath #(.W(PIN_COUNT)) u_inpath (
        .clk(clk), .rst(rst), .pin_in(pin_in), .pol(pol),
        .din_adj(din_adj), .din_prev(din_prev), .rise(rise)
    );

    gpio_bank_blink #(.EXP(BLINK_EXP)) u_blink (
        .clk(clk), .rst(rst), .phase(phase)
    );

    for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
        assign pin_out[i] = blink[i] ? phase : dout[i];
        assign pend[i]    = (cause[i] & emask[i]) | (din_adj[i] & lmask[i]);
    end

    assign pin_oe_n = oen;
    assign irq      = |pend;

    always_comb begin
        case (reg_addr_e'(reg_addr))
            RA_DOUT:  reg_rdata = dout;
            RA_OEN:   reg_rdata = oen;
            RA_BLINK: reg_rdata = blink;
            RA_POL:   reg_rdata = pol;
            RA_DIN:   reg_rdata = din_adj;
            RA_CAUSE: reg_rdata = cause;
            RA_EMASK: reg_rdata = emask;
            default:  reg_rdata = lmask;
        endcase
    end

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         reg_we,
    input logic [2:0]   reg_addr,
    input logic [W-1:0] reg_wdata,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] pin_oe_n,
    input logic         irq,
    input logic [W-1:0] dout,
    input logic [W-1:0] blink,
    input logic [W-1:0] cause,
    input logic [W-1:0] emask,
    input logic [W-1:0] lmask,
    input logic [W-1:0] din_adj,
    input logic [W-1:0] din_prev
);

    p_oe_follows_r1: assert property (@(posedge clk) disable iff (rst)
        $past(reg_we && reg_addr == 3'd1 && !rst) |-> pin_oe_n == $past(reg_wdata));

    p_static_out_r2: assert property (@(posedge clk) disable iff (rst)
        (blink == '0) |-> (pin_out == dout));

    p_cause_origin_r5: assert property (@(posedge clk) disable iff (rst)
        ((cause & ~$past(cause)) & ~$past(din_adj & ~din_prev)) == '0);

    p_cause_clear_r6: assert property (@(posedge clk) disable iff (rst)
        $past(reg_we && reg_addr == 3'd5 && !rst) |->
            (cause & ~$past(reg_wdata) & ~$past(din_adj & ~din_prev)) == '0);

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (rst)
        (emask == '0 && lmask == '0) |-> !irq);

endmodule

bind gpio_bank gpio_bank_chk #(.W(PIN_COUNT)) i_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pin_out(pin_out), .pin_oe_n(pin_oe_n), .irq(irq),
    .dout(dout), .blink(blink), .cause(cause), .emask(emask), .lmask(lmask),
    .din_adj(din_adj), .din_prev(din_prev)
);

// File: tb/test_gpio_bank.sv
module test_gpio_bank;

    localparam int W   = 32;
    localparam int EXP = 3;

    logic         clk = 1'b0;
    logic         rst;
    logic         reg_we;
    logic [2:0]   reg_addr;
    logic [W-1:0] reg_wdata;
    logic [W-1:0] reg_rdata;
    logic [W-1:0] pin_in;
    logic [W-1:0] pin_out;
    logic [W-1:0] pin_oe_n;
    logic         irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference model state
    logic [W-1:0] m_dout, m_oen, m_blink, m_pol, m_inq, m_prev, m_cause, m_em, m_lm;
    int m_cyc;

    always #4 clk = ~clk;

    gpio_bank #(.PIN_COUNT(W), .BLINK_EXP(EXP)) i_gpio_bank (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe_n(pin_oe_n), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cycles);
        end
    endtask

    function automatic logic [W-1:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_dout;
            3'd1: return m_oen;
            3'd2: return m_blink;
            3'd3: return m_pol;
            3'd4: return m_inq ^ m_pol;
            3'd5: return m_cause;
            3'd6: return m_em;
            default: return m_lm;
        endcase
    endfunction

    task automatic compare();
        logic [W-1:0] exp_out;
        logic         ph;
        logic         exp_irq;
        string        rtag;
        ph = ((m_cyc / (1 << EXP)) % 2) == 1;
        for (int i = 0; i < W; i++) exp_out[i] = m_blink[i] ? ph : m_dout[i];
        exp_irq = |((m_cause & m_em) | ((m_inq ^ m_pol) & m_lm));
        check(pin_oe_n === m_oen, "R1 driver enable", pin_oe_n, m_oen);
        check(pin_out === exp_out, (m_blink != 0) ? "R3 blink output" : "R2 static output",
              pin_out, exp_out);
        check(irq === exp_irq, "R7 interrupt", {31'b0, irq}, {31'b0, exp_irq});
        case (reg_addr)
            3'd4:    rtag = "R4 data-in read";
            3'd5:    rtag = "R5/R6 cause read";
            default: rtag = "R9 register read";
        endcase
        check(reg_rdata === model_read(reg_addr), rtag, reg_rdata, model_read(reg_addr));
    endtask

    task automatic step();
        logic [W-1:0] rise;
        rise = (m_inq ^ m_pol) & ~m_prev;
        @(posedge clk);
        cycles++;
        if (rst) begin
            m_dout = '0; m_oen = '1; m_blink = '0; m_pol = '0; m_inq = '0;
            m_prev = '0; m_cause = '0; m_em = '0; m_lm = '0; m_cyc = 0;
        end else begin
            m_prev = m_inq ^ m_pol;
            m_inq  = pin_in;
            m_cyc  = m_cyc + 1;
            m_cause = ((reg_we && reg_addr == 3'd5) ? (m_cause & reg_wdata) : m_cause) | rise;
            if (reg_we) begin
                case (reg_addr)
                    3'd0: m_dout  = reg_wdata;
                    3'd1: m_oen   = reg_wdata;
                    3'd2: m_blink = reg_wdata;
                    3'd3: m_pol   = reg_wdata;
                    3'd6: m_em    = reg_wdata;
                    3'd7: m_lm    = reg_wdata;
                    default: ;
                endcase
            end
        end
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a);
        reg_addr = a;
        step();
    endtask

    initial begin
        while (cycles < 100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = '0; pin_in = '0;
        m_cyc = 0;
        @(negedge clk);
        step(); step();
        rst = 1'b0;
        // R8: reset values across the map
        for (int a = 0; a < 8; a++) rd(3'(a));

        // R9: write and read back, data-in write ignored
        wr(3'd0, 32'hA5A5_0F0F); rd(3'd0);
        wr(3'd2, 32'h0000_0000); rd(3'd2);
        wr(3'd4, 32'hFFFF_FFFF); rd(3'd4);
        wr(3'd6, 32'h0); wr(3'd7, 32'h0);

        // R1: driver enables
        wr(3'd1, 32'h0000_FFFF); rd(3'd1);
        wr(3'd1, 32'hF0F0_0000); rd(3'd1);

        // R4: sampled input with polarity
        pin_in = 32'h1234_5678; rd(3'd4); rd(3'd4);
        wr(3'd3, 32'hFFFF_0000); rd(3'd4);
        pin_in = 32'hDEAD_BEEF; rd(3'd4); rd(3'd4);

        // R5: causes from rises, including polarity flips; falls ignored
        rd(3'd5);
        wr(3'd5, 32'h0); rd(3'd5);
        pin_in = 32'h0; rd(3'd5); rd(3'd5);
        pin_in = 32'h0000_00F0; rd(3'd5); rd(3'd5);
        wr(3'd3, 32'h0); rd(3'd5); rd(3'd5);

        // R6: clear by zero bits, keep by one bits, rise beats clear
        wr(3'd5, 32'hFFFF_00F0); rd(3'd5);
        wr(3'd5, 32'h0000_00C0); rd(3'd5);
        pin_in = 32'h0000_0F00; step();
        wr(3'd5, 32'h0); rd(3'd5);
        wr(3'd5, 32'h0); rd(3'd5);

        // R7: edge and level masks
        pin_in = 32'h0000_0001; rd(3'd5); rd(3'd5);
        wr(3'd6, 32'h0000_0002); rd(3'd5);
        wr(3'd6, 32'h0000_0001); rd(3'd5);
        wr(3'd5, 32'h0); rd(3'd5);
        wr(3'd7, 32'h8000_0000); rd(3'd4);
        pin_in = 32'h8000_0000; rd(3'd4); rd(3'd4);
        wr(3'd3, 32'h8000_0000); rd(3'd4);
        wr(3'd6, 32'h0); wr(3'd7, 32'h0); wr(3'd5, 32'h0);

        // R2/R3: mixed blink and static pins over several periods
        wr(3'd0, 32'h00FF_00FF);
        wr(3'd2, 32'hF000_000F);
        for (int k = 0; k < 40; k++) rd(3'd2);
        wr(3'd2, 32'h0); rd(3'd0);

        // R8: reset in mid-run
        pin_in = 32'hFFFF_FFFF; wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd5); rd(3'd5);
        rst = 1'b1; step(); rst = 1'b0;
        pin_in = 32'h0;
        for (int a = 0; a < 8; a++) rd(3'(a));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule